// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block is the host-side consumer of a small circular ring of receive descriptors held in local registers. A receive engine, modelled by a write port, deposits completed command/status words into the ring. The consumer watches the descriptor at its current index. Once that descriptor is marked complete, it works out the frame length and decides whether the frame is good or corrupted. It presents that verdict on a valid/ready result port, hands the descriptor back in the armed state, steps to the next index and pulses a strobe that restarts the receive engine.

A peek input lets the host ask only whether a completed descriptor is waiting, without consuming it. A view port reads any descriptor's status word, link word and buffer pointer, so the ring's contents can be inspected at any time.

Top module: `rx_ring_reaper`

## Requirements
- R1: After a synchronous reset the current index is 0 and no result is valid. Each descriptor i holds the status word 1536 with bit 31 clear, a link word equal to DESC_BASE + 16*((i+1) mod 4), and a buffer pointer equal to BUF_BASE + 1536*i. The defaults are DESC_BASE = 0x4000 and BUF_BASE = 0x20000.
- R2: `pending_o` follows bit 31 (the ownership flag) of the status word at the current index. A descriptor is consumed only when that bit is set. The result appears one clock edge after the bit becomes visible. Completed descriptors at other indices are not consumed.
- R3: The reported length is status bits [11:0] minus 4, taken in 12 bits.
- R4: A frame is good only when bit 30 is 0, bit 27 is 1 and bit 22 is 0. Every other combination of these three bits is reported as corrupted.
- R5: When a descriptor is consumed, its status word becomes 1536 with bit 31 clear. Its buffer pointer is restored to BUF_BASE + 1536*index. This happens whether the frame was good or corrupted.
- R6: The current index steps by one per consumed descriptor and wraps from 3 to 0. `res_idx_o` reports the index that was consumed.
- R7: `restart_o` is high for exactly the clock in which each new result first becomes valid. Back-to-back consumptions give one high cycle per descriptor.
- R8: While `res_valid_o` is high and `res_ready_i` is low, the result fields hold steady, no descriptor is consumed and the index stays put. A handshake and the next consumption may happen on the same edge.
- R9: While `peek_mode_i` is high, nothing is consumed. The descriptor keeps its status word, and `pending_o` still reports its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| dma_wr_en_i | input | 1 | Receive-engine write strobe for a status word |
| dma_wr_idx_i | input | 2 | Descriptor index written |
| dma_wr_data_i | input | 32 | Status word written |
| peek_mode_i | input | 1 | Report presence only, never consume |
| pending_o | output | 1 | Descriptor at the current index is complete |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted |
| res_good_o | output | 1 | Frame classified good |
| res_len_o | output | 12 | Frame length without CRC |
| res_idx_o | output | 2 | Index the result came from |
| restart_o | output | 1 | Receiver restart strobe |
| cur_idx_o | output | 2 | Current ring index |
| view_idx_i | input | 2 | Descriptor selected for inspection |
| view_cmdsts_o | output | 32 | Status word of the selected descriptor |
| view_link_o | output | 32 | Link word of the selected descriptor |
| view_bufptr_o | output | 32 | Buffer pointer of the selected descriptor |

## Verification
A wrong index shows up at the edge after the next consumption, in two ways: `res_idx_o` breaks its 0,1,2,3,0 sequence, and the status word of the wrong slot is the one re-armed on the view port. A missed re-arm leaves bit 31 set on the view port, and the ring consumes the slot a second time when it comes round again. A broken stall or peek path shows within one cycle: the result fields change, a restart pulse appears, or `cur_idx_o` moves while it should hold.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    localparam int OWN_BIT   = 31;
    localparam int MORE_BIT  = 30;
    localparam int OK_BIT    = 27;
    localparam int LONG_BIT  = 22;
    localparam int SIZE_W    = 12;
    localparam int CRC_BYTES = 4;

    typedef struct packed {
        logic              good;
        logic [SIZE_W-1:0] len;
    } verdict_t;
endpackage

// File: rtl/rx_desc_file.sv
module rx_desc_file import rx_ring_pkg::*; #(
    parameter int          DEPTH       = 4,
    parameter int          BUF_BYTES   = 1536,
    parameter logic [31:0] BUF_BASE    = 32'h0002_0000,
    parameter logic [31:0] DESC_BASE   = 32'h0000_4000,
    parameter int          DESC_STRIDE = 16,
    localparam int         IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [31:0]       wr_data_i,
    input  logic              arm_en_i,
    input  logic [IDX_W-1:0]  arm_idx_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_own_o,
    output logic [2:0]        rd_flags_o,
    output logic [SIZE_W-1:0] rd_size_o,
    input  logic [IDX_W-1:0]  view_idx_i,
    output logic [31:0]       view_cmd_o,
    output logic [31:0]       view_link_o,
    output logic [31:0]       view_ptr_o
);
    localparam logic [31:0] ARMED_WORD = 32'(BUF_BYTES);

    typedef struct packed {
        logic [DEPTH-1:0][31:0] cmd;
        logic [DEPTH-1:0][31:0] link;
        logic [DEPTH-1:0][31:0] ptr;
    } file_t;

    file_t file_d, file_q;

    always_comb begin
        file_d = file_q;
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                file_d.cmd[i]  = ARMED_WORD;
                file_d.link[i] = DESC_BASE + 32'(((i + 1) % DEPTH) * DESC_STRIDE);
                file_d.ptr[i]  = BUF_BASE + 32'(i * BUF_BYTES);
            end
        end else begin
            if (wr_en_i) file_d.cmd[wr_idx_i] = wr_data_i;
            // the consumer's re-arm takes priority over a write to the same slot
            if (arm_en_i) begin
                file_d.cmd[arm_idx_i] = ARMED_WORD;
                file_d.ptr[arm_idx_i] = BUF_BASE + 32'(arm_idx_i) * 32'(BUF_BYTES);
            end
        end
    end

    always_ff @(posedge clk_i) file_q <= file_d;

    logic [31:0] rd_word;
    assign rd_word    = file_q.cmd[rd_idx_i];
    assign rd_own_o   = rd_word[OWN_BIT];
    assign rd_flags_o = {rd_word[MORE_BIT], rd_word[OK_BIT], rd_word[LONG_BIT]};
    assign rd_size_o  = rd_word[SIZE_W-1:0];

    assign view_cmd_o  = file_q.cmd[view_idx_i];
    assign view_link_o = file_q.link[view_idx_i];
    assign view_ptr_o  = file_q.ptr[view_idx_i];

    // R5
    rearm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        arm_en_i |=> (file_q.cmd[$past(arm_idx_i)] == ARMED_WORD));
endmodule

// File: rtl/rx_frame_classify.sv
module rx_frame_classify import rx_ring_pkg::*; (
    input  logic [2:0]        flags_i,
    input  logic [SIZE_W-1:0] size_i,
    output verdict_t          verdict_o
);
    // flags_i = {more, ok, too_long}
    assign verdict_o.good = (flags_i == 3'b010);
    assign verdict_o.len  = size_i - SIZE_W'(CRC_BYTES);
endmodule

// File: rtl/rx_ring_reaper.sv
module rx_ring_reaper import rx_ring_pkg::*; #(
    parameter int          RING_DEPTH  = 4,
    parameter int          BUF_BYTES   = 1536,
    parameter logic [31:0] BUF_BASE    = 32'h0002_0000,
    parameter logic [31:0] DESC_BASE   = 32'h0000_4000,
    parameter int          DESC_STRIDE = 16,
    localparam int         IDX_W       = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              dma_wr_en_i,
    input  logic [IDX_W-1:0]  dma_wr_idx_i,
    input  logic [31:0]       dma_wr_data_i,
    input  logic              peek_mode_i,
    output logic              pending_o,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              res_good_o,
    output logic [SIZE_W-1:0] res_len_o,
    output logic [IDX_W-1:0]  res_idx_o,
    output logic              restart_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    input  logic [IDX_W-1:0]  view_idx_i,
    output logic [31:0]       view_cmdsts_o,
    output logic [31:0]       view_link_o,
    output logic [31:0]       view_bufptr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             valid;
        verdict_t         res;
        logic [IDX_W-1:0] res_idx;
        logic             restart;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              cur_own;
    logic [2:0]        cur_flags;
    logic [SIZE_W-1:0] cur_size;
    verdict_t          verdict;
    logic              take;

    rx_desc_file #(
        .DEPTH(RING_DEPTH), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE),
        .DESC_BASE(DESC_BASE), .DESC_STRIDE(DESC_STRIDE)
    ) ring_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (dma_wr_en_i),
        .wr_idx_i   (dma_wr_idx_i),
        .wr_data_i  (dma_wr_data_i),
        .arm_en_i   (take),
        .arm_idx_i  (ctl_q.idx),
        .rd_idx_i   (ctl_q.idx),
        .rd_own_o   (cur_own),
        .rd_flags_o (cur_flags),
        .rd_size_o  (cur_size),
        .view_idx_i (view_idx_i),
        .view_cmd_o (view_cmdsts_o),
        .view_link_o(view_link_o),
        .view_ptr_o (view_bufptr_o)
    );

    rx_frame_classify sort_i (
        .flags_i  (cur_flags),
        .size_i   (cur_size),
        .verdict_o(verdict)
    );

    assign take = !rst_i && !peek_mode_i && cur_own && (!ctl_q.valid || res_ready_i);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.restart = 1'b0;
        if (rst_i) begin
            ctl_d = '0;
        end else begin
            if (ctl_q.valid && res_ready_i) ctl_d.valid = 1'b0;
            if (take) begin
                ctl_d.valid   = 1'b1;
                ctl_d.res     = verdict;
                ctl_d.res_idx = ctl_q.idx;
                ctl_d.restart = 1'b1;
                ctl_d.idx     = (ctl_q.idx == LAST_IDX) ? '0 : ctl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) ctl_q <= ctl_d;

    assign pending_o   = cur_own;
    assign res_valid_o = ctl_q.valid;
    assign res_good_o  = ctl_q.res.good;
    assign res_len_o   = ctl_q.res.len;
    assign res_idx_o   = ctl_q.res_idx;
    assign restart_o   = ctl_q.restart;
    assign cur_idx_o   = ctl_q.idx;

    // R8
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && !restart_o &&
            $stable(res_len_o) && $stable(res_good_o) && $stable(res_idx_o) && $stable(cur_idx_o)));
    // R9
    peek_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        peek_mode_i |=> !restart_o);
    // R6
    idx_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o |-> (cur_idx_o == (($past(cur_idx_o) == LAST_IDX) ? '0 : $past(cur_idx_o) + 1'b1)));
    // R2
    own_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o |-> $past(pending_o));
    // R7
    strobe_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o |-> res_valid_o);
endmodule

// File: tb/rx_ring_reaper_tb.sv
module rx_ring_reaper_tb_top;
    localparam logic [31:0] E_BUF_BASE  = 32'h0002_0000;
    localparam logic [31:0] E_DESC_BASE = 32'h0000_4000;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] MORE = 32'h4000_0000;
    localparam logic [31:0] OK   = 32'h0800_0000;
    localparam logic [31:0] LONG = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        peek = 1'b0;
    logic        ready = 1'b1;
    logic [1:0]  view_idx = '0;
    logic        pending, valid, good, restart;
    logic [11:0] len;
    logic [1:0]  res_idx, cur_idx;
    logic [31:0] v_cmd, v_link, v_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_ring_reaper dut_i (
        .clk_i(clk), .rst_i(rst),
        .dma_wr_en_i(wr_en), .dma_wr_idx_i(wr_idx), .dma_wr_data_i(wr_data),
        .peek_mode_i(peek), .pending_o(pending),
        .res_valid_o(valid), .res_ready_i(ready), .res_good_o(good),
        .res_len_o(len), .res_idx_o(res_idx), .restart_o(restart),
        .cur_idx_o(cur_idx), .view_idx_i(view_idx),
        .view_cmdsts_o(v_cmd), .view_link_o(v_link), .view_bufptr_o(v_ptr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a negative edge
    task automatic write_desc(input logic [1:0] idx, input logic [31:0] w);
        wr_en = 1'b1; wr_idx = idx; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_result(input string req, input logic g, input logic [11:0] l, input logic [1:0] i);
        chk({req, " valid"}, 32'(valid), 32'd1);
        chk({req, " restart"}, 32'(restart), 32'd1);
        chk({req, " good"}, 32'(good), 32'(g));
        chk({req, " len"}, 32'(len), 32'(l));
        chk({req, " idx"}, 32'(res_idx), 32'(i));
    endtask

    task automatic t_reset();
        chk("R1 cur_idx", 32'(cur_idx), 32'd0);
        chk("R1 valid", 32'(valid), 32'd0);
        chk("R1 pending", 32'(pending), 32'd0);
        for (int i = 0; i < 4; i++) begin
            view_idx = 2'(i);
            #1;
            chk("R1 cmdsts", v_cmd, 32'd1536);
            chk("R1 link", v_link, E_DESC_BASE + 32'(((i + 1) % 4) * 16));
            chk("R1 bufptr", v_ptr, E_BUF_BASE + 32'(i * 1536));
        end
    endtask

    task automatic t_good();
        write_desc(2'd0, OWN | OK | 32'd100);
        chk("R2 pending", 32'(pending), 32'd1);
        @(negedge clk);
        check_result("R3 R4 good", 1'b1, 12'd96, 2'd0);
        chk("R6 step", 32'(cur_idx), 32'd1);
        view_idx = 2'd0; #1;
        chk("R5 rearm", v_cmd, 32'd1536);
        chk("R5 ptr", v_ptr, E_BUF_BASE);
        @(negedge clk);
        chk("R7 single pulse", 32'(restart), 32'd0);
        chk("R8 handshake done", 32'(valid), 32'd0);
    endtask

    task automatic t_corrupt();
        write_desc(2'd1, OWN | OK | MORE | 32'd300);
        @(negedge clk);
        check_result("R4 more", 1'b0, 12'd296, 2'd1);
        write_desc(2'd2, OWN | OK | LONG | 32'd2000);
        @(negedge clk);
        check_result("R4 long", 1'b0, 12'd1996, 2'd2);
        write_desc(2'd3, OWN | 32'd64);
        @(negedge clk);
        check_result("R4 no ok", 1'b0, 12'd60, 2'd3);
        chk("R6 wrap", 32'(cur_idx), 32'd0);
        view_idx = 2'd2; #1;
        chk("R5 bad rearm", v_cmd, 32'd1536);
        @(negedge clk);
    endtask

    task automatic t_stall();
        ready = 1'b0;
        write_desc(2'd0, OWN | OK | 32'd70);
        write_desc(2'd1, OWN | OK | 32'd80);
        check_result("R8 first", 1'b1, 12'd66, 2'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 hold valid", 32'(valid), 32'd1);
            chk("R8 hold len", 32'(len), 32'd66);
            chk("R8 no restart", 32'(restart), 32'd0);
            chk("R8 idx hold", 32'(cur_idx), 32'd1);
        end
        view_idx = 2'd1; #1;
        chk("R8 slot untouched", v_cmd, OWN | OK | 32'd80);
        ready = 1'b1;
        @(negedge clk);
        check_result("R8 release", 1'b1, 12'd76, 2'd1);
        @(negedge clk);
        chk("R8 drained", 32'(valid), 32'd0);
    endtask

    task automatic t_peek();
        peek = 1'b1;
        write_desc(2'd2, OWN | OK | 32'd200);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 pending", 32'(pending), 32'd1);
            chk("R9 no valid", 32'(valid), 32'd0);
            chk("R9 idx", 32'(cur_idx), 32'd2);
        end
        view_idx = 2'd2; #1;
        chk("R9 kept", v_cmd, OWN | OK | 32'd200);
        peek = 1'b0;
        @(negedge clk);
        check_result("R9 after peek", 1'b1, 12'd196, 2'd2);
        @(negedge clk);
    endtask

    task automatic t_order();
        // index is 3: a completed slot 0 must wait its turn
        write_desc(2'd0, OWN | OK | 32'd90);
        chk("R2 other slot", 32'(pending), 32'd0);
        @(negedge clk);
        chk("R2 not consumed", 32'(valid), 32'd0);
        write_desc(2'd3, OWN | OK | 32'd60);
        @(negedge clk);
        check_result("R6 slot3", 1'b1, 12'd56, 2'd3);
        @(negedge clk);
        check_result("R7 back to back", 1'b1, 12'd86, 2'd0);
        chk("R6 after wrap", 32'(cur_idx), 32'd1);
        @(negedge clk);
        chk("R7 pulse end", 32'(restart), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_good();
        t_corrupt();
        t_stall();
        t_peek();
        t_order();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule